// File: doc/BRIEF.md
# Serial Two-Bit Frame Check Generator

This block builds a two-bit check value over a serial frame of a fixed number of data bits (65 by default). The frame is made of a 32-bit rolling code, a 32-bit fixed identifier and one low-battery status bit. Bits arrive one per cycle on a data input, qualified by a valid strobe.

The check register starts from zero. For every accepted bit it advances by a two-bit linear recurrence. Once the last bit of the window has been taken, a done flag rises and later data bits are dropped. After that, a serialiser hands out the two check bits on request so that they can be appended to the transmitted frame. A clear input restarts the whole block for the next frame.

Top module: `crc2s_gen`

## Requirements
- R1: After reset, `crc_o` is 2'b00, `done_o` is 0 and `out_vld_o` is 0.
- R2: On a cycle with `bit_vld_i`=1, `clr_i`=0 and `done_o`=0, the register updates at the next edge as follows. Here t = `crc_o[0]` XOR `bit_i`. The new `crc_o[1]` is t, and the new `crc_o[0]` is t XOR the old `crc_o[1]`.
- R3: `clr_i`=1 sets `crc_o` to 0, clears `done_o`, resets the serialiser and drives `out_vld_o` low at the next edge. It wins over a valid bit or a request in the same cycle.
- R4: A cycle with `bit_vld_i`=0 leaves `crc_o` and the count of accepted bits unchanged.
- R5: `done_o` rises at the edge that accepts the 65th valid bit (FRAME_BITS) since the last clear or reset. It stays 0 after 64 accepted bits.
- R6: While `done_o`=1, valid bits are ignored: `crc_o` and `done_o` keep their values until the next clear.
- R7: While `done_o`=1, the first `out_req_i` produces `out_vld_o`=1 one cycle later with `out_bit_o` = `crc_o[1]` and `out_last_o`=0. The second request does the same with `out_bit_o` = `crc_o[0]` and `out_last_o`=1.
- R8: A request made while `done_o`=0, or any request after both check bits have been emitted, gives `out_vld_o`=0 one cycle later.
- R9: Flipping any single bit of the 65-bit frame changes the final `crc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear / start of a new frame |
| bit_vld_i | input | 1 | Data bit strobe |
| bit_i | input | 1 | Serial data bit |
| out_req_i | input | 1 | Request for the next check bit |
| done_o | output | 1 | Whole window has been absorbed |
| crc_o | output | 2 | Current check register |
| out_vld_o | output | 1 | Emitted check bit valid |
| out_bit_o | output | 1 | Emitted check bit |
| out_last_o | output | 1 | Marks the second emitted check bit |

## Verification
The bench sends bits at a boundary count and with gaps between valid strobes. A design with an off-by-one bit counter would raise done after 64 or 66 bits. A design that advanced on idle cycles would end with a wrong check value.

It feeds bits after done and checks that they are ignored. Absorbing them would corrupt the appended value.

It asserts clear together with a valid bit and checks that clear wins. It sends emission requests before done and more than two after done, which catches a serialiser that emits early, emits twice or swaps the bit order.

Frames with single flipped bits are sent at the ends of each field. Each must give a check value different from the clean frame, which exposes a wrong feedback term.

// File: rtl/crc2s_pkg.sv
package crc2s_pkg;

   typedef enum logic [1:0] {
      EM_FIRST  = 2'd0,
      EM_SECOND = 2'd1,
      EM_SPENT  = 2'd2
   } emit_st_e;

   // One step of the two-bit recurrence.
   function automatic logic [1:0] crc2_step(input logic [1:0] cur, input logic din);
      logic t;
      t = cur[0] ^ din;
      return {t, t ^ cur[1]};
   endfunction

endpackage

// File: rtl/crc2s_counter.sv
module crc2s_counter #(
   parameter int FRAME_BITS = 65,
   localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic vld,
   output logic take,
   output logic done
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign take = vld & ~done_q & ~clr;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (take) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (cnt_q == LAST) begin
            done_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/crc2s_core.sv
module crc2s_core
   import crc2s_pkg::*;
#(
   parameter int CRC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             take,
   input  logic             din,
   output logic [CRC_W-1:0] crc
);
   logic [CRC_W-1:0] crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (clr) begin
         crc_q <= '0;
      end else if (take) begin
         crc_q <= crc2_step(crc_q, din);
      end
   end

   assign crc = crc_q;
endmodule

// File: rtl/crc2s_emitter.sv
module crc2s_emitter
   import crc2s_pkg::*;
#(
   parameter int CRC_W     = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             req,
   input  logic             ready,
   input  logic [CRC_W-1:0] crc,
   output logic             vld,
   output logic             bit_o,
   output logic             last
);
   emit_st_e st_q;
   logic     first_bit;
   logic     second_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign first_bit  = crc[1];
         assign second_bit = crc[0];
      end else begin : g_lsb
         assign first_bit  = crc[0];
         assign second_bit = crc[1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= EM_FIRST;
         vld   <= 1'b0;
         bit_o <= 1'b0;
         last  <= 1'b0;
      end else if (clr) begin
         st_q <= EM_FIRST;
         vld  <= 1'b0;
         last <= 1'b0;
      end else if (req && ready && st_q != EM_SPENT) begin
         vld <= 1'b1;
         if (st_q == EM_FIRST) begin
            bit_o <= first_bit;
            last  <= 1'b0;
            st_q  <= EM_SECOND;
         end else begin
            bit_o <= second_bit;
            last  <= 1'b1;
            st_q  <= EM_SPENT;
         end
      end else begin
         vld  <= 1'b0;
         last <= 1'b0;
      end
   end
endmodule

// File: rtl/crc2s_gen.sv
module crc2s_gen #(
   parameter int FRAME_BITS = 65,
   parameter int CRC_W      = 2,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic             out_req_i,
   output logic             done_o,
   output logic [CRC_W-1:0] crc_o,
   output logic             out_vld_o,
   output logic             out_bit_o,
   output logic             out_last_o
);
   generate
      if (FRAME_BITS < 2) begin : g_bad_len
         $error("crc2s_gen: FRAME_BITS must be at least 2");
      end
      if (CRC_W != 2) begin : g_bad_width
         $error("crc2s_gen: recurrence is defined for CRC_W == 2 only");
      end
   endgenerate

   logic take;

   crc2s_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_i),
      .vld  (bit_vld_i),
      .take (take),
      .done (done_o)
   );

   crc2s_core #(.CRC_W(CRC_W)) u_core (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_i),
      .take (take),
      .din  (bit_i),
      .crc  (crc_o)
   );

   crc2s_emitter #(.CRC_W(CRC_W), .MSB_FIRST(MSB_FIRST)) u_emit (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_i),
      .req  (out_req_i),
      .ready(done_o),
      .crc  (crc_o),
      .vld  (out_vld_o),
      .bit_o(out_bit_o),
      .last (out_last_o)
   );
endmodule

// File: rtl/crc2s_chk.sv
module crc2s_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       clr_i,
   input logic       bit_vld_i,
   input logic       bit_i,
   input logic       done_o,
   input logic [1:0] crc_o,
   input logic       out_vld_o,
   input logic       out_bit_o,
   input logic       out_last_o
);
   // R2
   step_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld_i && !done_o && !clr_i) |=> crc_o[1] == ($past(crc_o[0]) ^ $past(bit_i)));

   // R2
   step_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld_i && !done_o && !clr_i) |=>
         crc_o[0] == ($past(crc_o[0]) ^ $past(bit_i) ^ $past(crc_o[1])));

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (crc_o == 2'b00) && !done_o && !out_vld_o);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld_i && !clr_i) |=> $stable(crc_o));

   // R6
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !clr_i) |=> done_o && $stable(crc_o));

   // R8
   emit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld_o |-> done_o);

   // R7
   first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld_o && !out_last_o) |-> out_bit_o == crc_o[1]);

   // R7
   second_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld_o && out_last_o) |-> out_bit_o == crc_o[0]);

   // R8
   no_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld_o && out_last_o && !clr_i) |=> !out_vld_o);
endmodule

bind crc2s_gen crc2s_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .bit_vld_i (bit_vld_i),
   .bit_i     (bit_i),
   .done_o    (done_o),
   .crc_o     (crc_o),
   .out_vld_o (out_vld_o),
   .out_bit_o (out_bit_o),
   .out_last_o(out_last_o)
);

// File: tb/crc2s_gen_tb.sv
module crc2s_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NBITS      = 65;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr_i = 1'b0;
   logic       bit_vld_i = 1'b0;
   logic       bit_i = 1'b0;
   logic       out_req_i = 1'b0;
   logic       done_o;
   logic [1:0] crc_o;
   logic       out_vld_o;
   logic       out_bit_o;
   logic       out_last_o;

   int n_chk = 0;
   int n_err = 0;

   // behavioural reference state
   int m_c1, m_c0, m_cnt, m_done, m_emit, m_ovld, m_obit, m_olast;

   always #(CLK_PERIOD/2) clk = ~clk;

   crc2s_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_i),
      .bit_vld_i (bit_vld_i),
      .bit_i     (bit_i),
      .out_req_i (out_req_i),
      .done_o    (done_o),
      .crc_o     (crc_o),
      .out_vld_o (out_vld_o),
      .out_bit_o (out_bit_o),
      .out_last_o(out_last_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model, updated on every edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_c1 = 0; m_c0 = 0; m_cnt = 0; m_done = 0;
         m_emit = 0; m_ovld = 0; m_obit = 0; m_olast = 0;
      end else if (clr_i) begin
         m_c1 = 0; m_c0 = 0; m_cnt = 0; m_done = 0;
         m_emit = 0; m_ovld = 0; m_olast = 0;
      end else begin
         if (out_req_i && m_done != 0 && m_emit < 2) begin
            m_ovld  = 1;
            m_obit  = (m_emit == 0) ? m_c1 : m_c0;
            m_olast = (m_emit == 1) ? 1 : 0;
            m_emit++;
         end else begin
            m_ovld = 0;
            m_olast = 0;
         end
         if (bit_vld_i && m_done == 0) begin
            int t;
            t = m_c0 ^ int'(bit_i);
            m_c0 = t ^ m_c1;
            m_c1 = t;
            m_cnt++;
            if (m_cnt == NBITS) m_done = 1;
         end
      end
   end

   // Compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2/R4 crc_o", int'(crc_o), m_c1 * 2 + m_c0);
         chk("R5/R6 done_o", int'(done_o), m_done);
         chk("R7/R8 out_vld_o", int'(out_vld_o), m_ovld);
         if (m_ovld != 0) begin
            chk("R7 out_bit_o", int'(out_bit_o), m_obit);
            chk("R7 out_last_o", int'(out_last_o), m_olast);
         end
      end
   end

   task automatic cyc(input logic c, input logic v, input logic b, input logic r);
      @(negedge clk);
      clr_i = c; bit_vld_i = v; bit_i = b; out_req_i = r;
   endtask

   function automatic logic [1:0] ref_crc(input logic [NBITS-1:0] f);
      int a1 = 0;
      int a0 = 0;
      for (int n = 0; n < NBITS; n++) begin
         int t;
         t = a0 ^ int'(f[n]);
         a0 = t ^ a1;
         a1 = t;
      end
      return 2'(a1 * 2 + a0);
   endfunction

   // Feeds a whole frame; gap>0 inserts idle cycles between bits
   task automatic send_frame(input logic [NBITS-1:0] f, input int gap);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      for (int n = 0; n < NBITS; n++) begin
         cyc(1'b0, 1'b1, f[n], 1'b0);
         for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, ~f[n], 1'b0);
      end
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [NBITS-1:0] frm;
      logic [1:0]       clean;
      logic [31:0]      hop;
      logic [31:0]      fix;
      hop = 32'hA5C3_1E77;
      fix = 32'h0F1D_9B42;
      frm = {1'b1, fix, hop};

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 crc_o", int'(crc_o), 0);
      chk("R1 done_o", int'(done_o), 0);
      chk("R1 out_vld_o", int'(out_vld_o), 0);
      rst_n = 1'b1;

      // R8: request before done is ignored; R5 boundary at 64 bits
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      for (int n = 0; n < NBITS - 1; n++) cyc(1'b0, 1'b1, frm[n], (n % 7) == 0);
      cyc(1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R5 done_o low after 64 bits", int'(done_o), 0);
      chk("R8 out_vld_o before done", int'(out_vld_o), 0);
      bit_vld_i = 1'b1; bit_i = frm[NBITS-1]; out_req_i = 1'b0;
      @(negedge clk);
      chk("R5 done_o high after 65 bits", int'(done_o), 1);
      chk("R2 frame value", int'(crc_o), int'(ref_crc(frm)));
      clean = crc_o;

      // R6: extra bits ignored
      bit_vld_i = 1'b1; bit_i = 1'b1;
      repeat (4) @(negedge clk);
      bit_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 crc_o unchanged after done", int'(crc_o), int'(clean));
      bit_vld_i = 1'b0;

      // R7 / R8: emission order and excess requests
      out_req_i = 1'b1;
      @(negedge clk);
      chk("R7 first bit valid", int'(out_vld_o), 1);
      chk("R7 first bit is crc[1]", int'(out_bit_o), int'(clean[1]));
      @(negedge clk);
      chk("R7 second bit is crc[0]", int'(out_bit_o), int'(clean[0]));
      chk("R7 second bit last", int'(out_last_o), 1);
      @(negedge clk);
      chk("R8 third request ignored", int'(out_vld_o), 0);
      out_req_i = 1'b0;

      // R3: clear wins over a simultaneous valid bit and request
      cyc(1'b1, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      chk("R3 crc_o cleared", int'(crc_o), 0);
      chk("R3 done_o cleared", int'(done_o), 0);
      chk("R3 out_vld_o cleared", int'(out_vld_o), 0);
      clr_i = 1'b0; bit_vld_i = 1'b0; out_req_i = 1'b0;

      // R4: frame with idle gaps gives the same value
      send_frame(frm, 2);
      chk("R4 gapped frame value", int'(crc_o), int'(clean));

      // R9: single-bit flips at field edges
      for (int k = 0; k < 7; k++) begin
         int pos;
         logic [NBITS-1:0] bad;
         case (k)
            0: pos = 0;
            1: pos = 1;
            2: pos = 31;
            3: pos = 32;
            4: pos = 50;
            5: pos = 63;
            default: pos = 64;
         endcase
         bad = frm;
         bad[pos] = ~bad[pos];
         send_frame(bad, 0);
         chk("R9 flipped frame differs", int'(crc_o != clean), 1);
         chk("R9 flipped frame value", int'(crc_o), int'(ref_crc(bad)));
      end

      // R2: all-ones and all-zeros frames
      send_frame({NBITS{1'b1}}, 0);
      chk("R2 all-ones frame", int'(crc_o), int'(ref_crc({NBITS{1'b1}})));
      send_frame({NBITS{1'b0}}, 1);
      chk("R2 all-zeros frame", int'(crc_o), 0);

      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule